// File: doc/BRIEF.md
# Multi-Register Memory Micro-Op Cracker

This block sits at the issue stage of a core whose register file has two read ports and a single write port. Because only one register can be written per micro-op, any memory or move instruction that touches more than one destination has to be broken apart before it enters the execute pipe. The cracker accepts one decoded instruction at a time and turns it into a sequence of single-register micro-ops. The instruction carries a kind code, a base register, a first register, a word count and a base-update flag. Each micro-op gives an operation code, a target register, a byte offset from the base, first/last markers and a forwarding marker.

Both edges use valid/ready handshakes. An instruction is taken when `in_valid` and `in_ready` are both high on a rising clock edge. `in_ready` is high only while no sequence is in progress. A micro-op is consumed when `uop_valid` and `uop_ready` are both high on a rising edge. While the consumer holds `uop_ready` low, the presented micro-op stays unchanged. Instructions that cannot be cracked are accepted and dropped, and `err_o` is raised for one cycle. The address adder and the memory access itself belong to later stages. The block only produces the offsets.

Top module: `uop_cracker`

## Requirements
- R1: After reset, `in_ready` is 1, and `uop_valid` and `err_o` are 0.
- R2: A load-multiple (kind 0) or store-multiple (kind 1) of N words, where N is 1 to 8 or 12, yields N data micro-ops. Micro-op i has op LOAD=0 or STORE=1, target register (first register + i) modulo 2^REG_W, and offset 4*i.
- R3: When the update flag is set on kind 0 or 1, one extra micro-op follows the last data micro-op. It has op BASEWB=4, targets the base register and has offset 4*N.
- R4: `uop_first` is 1 only on the first micro-op of a sequence, and `uop_last` is 1 only on its final one. The first micro-op is presented in the cycle after acceptance.
- R5: `uop_fwd` is 1 on the last data micro-op of a load-multiple and on the load of a single load with update. It is 0 on every other micro-op.
- R6: A single load with update (kind 2) yields two micro-ops: a LOAD to the first register at offset 0, then a BASEWB to the base register at offset 4. The count and update inputs are ignored for this kind.
- R7: A register-offset store (kind 3) yields two micro-ops: ADDR=3 on the base register at offset 0, then a STORE of the first register at offset 0.
- R8: A double-word move (kind 4) yields two MOVE=2 micro-ops. The first targets the first register with bit 0 cleared, and the second targets it with bit 0 set.
- R9: `in_ready` is 0 from the cycle after acceptance until the final micro-op is taken. It is 1 again in the following cycle, and no micro-op is presented while `in_ready` is 1.
- R10: While `uop_valid` is 1 and `uop_ready` is 0, all micro-op outputs hold their values into the next cycle.
- R11: A kind 0 or 1 instruction with a count of 0 or outside {1..8, 12} is accepted, raises `err_o` for exactly the cycle after acceptance, emits no micro-op, and leaves `in_ready` at 1.
- R12: Asserting reset in the middle of a sequence returns the block to the idle state of R1 and discards the remaining micro-ops.
- R13: Kind codes 5, 6 and 7 are rejected in the same way as R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Cracker idle, instruction may be taken |
| in_kind | input | 3 | 0 load-multiple, 1 store-multiple, 2 load with update, 3 register-offset store, 4 double move |
| in_base | input | REG_W | Base register |
| in_rfirst | input | REG_W | First data register |
| in_count | input | CNT_W | Word count for kinds 0 and 1 |
| in_upd | input | 1 | Base writeback requested, kinds 0 and 1 |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_op | output | 3 | 0 LOAD, 1 STORE, 2 MOVE, 3 ADDR, 4 BASEWB |
| uop_reg | output | REG_W | Target register |
| uop_ofs | output | OFS_W | Byte offset from base |
| uop_first | output | 1 | First micro-op of the sequence |
| uop_last | output | 1 | Final micro-op of the sequence |
| uop_fwd | output | 1 | Result to forward to dependent consumers |
| err_o | output | 1 | One-cycle pulse for a rejected instruction |

## Verification
The per-cycle properties cover the handshake rules:
- the hold-under-stall rule of R10;
- the mutual exclusion of `in_ready` and `uop_valid`;
- the first micro-op following each acceptance;
- the return to ready after a final micro-op;
- the absence of micro-ops during an error pulse;
- forwarding appearing only on loads;
- the idle state under reset.

Only the bench scenarios can show that the register numbering, wrap-around, offsets, base-writeback placement and even/odd split come out in the right order for each kind and each count. They also show that every illegal count or kind is dropped without a single micro-op.

// File: rtl/uop_cracker_pkg.sv
package uop_cracker_pkg;

  // instruction kind codes seen on in_kind
  localparam logic [2:0] KIND_LDM  = 3'd0;
  localparam logic [2:0] KIND_STM  = 3'd1;
  localparam logic [2:0] KIND_LDU  = 3'd2;
  localparam logic [2:0] KIND_STR  = 3'd3;
  localparam logic [2:0] KIND_MOVD = 3'd4;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_MOVE   = 3'd2,
    OP_ADDR   = 3'd3,
    OP_BASEWB = 3'd4
  } uop_op_e;

  // legal run lengths: 1..short_max plus one extra wide length
  function automatic logic run_len_ok(input int unsigned n,
                                      input int unsigned short_max,
                                      input int unsigned wide_len);
    return ((n >= 1) && (n <= short_max)) || (n == wide_len);
  endfunction

endpackage

// File: rtl/uop_cracker_admit.sv
module uop_cracker_admit
  import uop_cracker_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int MAX_RUN  = 8,
  parameter int WIDE_RUN = 12,
  localparam int IW      = CNT_W + 1
) (
  input  logic [2:0]       kind,
  input  logic [CNT_W-1:0] count,
  input  logic             upd,
  output logic             legal,
  output logic [CNT_W-1:0] n_data,
  output logic [IW-1:0]    n_total
);

  always_comb begin
    legal   = 1'b1;
    n_data  = '0;
    n_total = '0;
    unique case (kind)
      KIND_LDM, KIND_STM: begin
        legal   = run_len_ok(int'(count), MAX_RUN, WIDE_RUN);
        n_data  = count;
        n_total = {1'b0, count} + IW'(upd);
      end
      KIND_LDU: begin
        // one load word, then the base writeback
        n_data  = CNT_W'(1);
        n_total = IW'(2);
      end
      KIND_STR, KIND_MOVD: begin
        n_data  = CNT_W'(2);
        n_total = IW'(2);
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/uop_cracker_ctrl.sv
module uop_cracker_ctrl #(
  parameter int REG_W = 5,
  parameter int CNT_W = 4,
  localparam int IW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_kind,
  input  logic [REG_W-1:0] in_base,
  input  logic [REG_W-1:0] in_rfirst,
  input  logic             legal,
  input  logic [CNT_W-1:0] n_data,
  input  logic [IW-1:0]    n_total,
  output logic [2:0]       kind_q,
  output logic [REG_W-1:0] base_q,
  output logic [REG_W-1:0] rfirst_q,
  output logic [CNT_W-1:0] ndata_q,
  output logic [IW-1:0]    idx_q,
  output logic             is_last,
  output logic             busy_q,
  input  logic             uop_ready,
  output logic             err_q
);

  logic [IW-1:0] total_q;
  logic          take;
  logic          step;

  assign in_ready = !busy_q;
  assign take     = in_valid && !busy_q;
  assign step     = busy_q && uop_ready;
  assign is_last  = (idx_q == total_q - IW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      kind_q   <= '0;
      base_q   <= '0;
      rfirst_q <= '0;
      ndata_q  <= '0;
      total_q  <= '0;
      idx_q    <= '0;
    end else begin
      err_q <= take && !legal;
      if (take && legal) begin
        busy_q   <= 1'b1;
        kind_q   <= in_kind;
        base_q   <= in_base;
        rfirst_q <= in_rfirst;
        ndata_q  <= n_data;
        total_q  <= n_total;
        idx_q    <= '0;
      end else if (step) begin
        if (is_last) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/uop_cracker_form.sv
module uop_cracker_form
  import uop_cracker_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int CNT_W      = 4,
  parameter int OFS_W      = 8,
  parameter int WORD_BYTES = 4,
  localparam int IW        = CNT_W + 1
) (
  input  logic [2:0]       kind,
  input  logic [REG_W-1:0] base,
  input  logic [REG_W-1:0] rfirst,
  input  logic [CNT_W-1:0] ndata,
  input  logic [IW-1:0]    idx,
  output uop_op_e          op,
  output logic [REG_W-1:0] rg,
  output logic [OFS_W-1:0] ofs
  ,output logic            fwd
);

  localparam logic [OFS_W-1:0] STRIDE = OFS_W'(WORD_BYTES);

  logic          in_data;
  logic          last_data;
  logic          is_load;
  logic [IW-1:0] ndata_x;

  assign ndata_x   = {1'b0, ndata};
  assign in_data   = idx < ndata_x;
  assign last_data = idx == ndata_x - IW'(1);
  assign is_load   = (kind == KIND_LDM) || (kind == KIND_LDU);

  always_comb begin
    op  = OP_LOAD;
    rg  = rfirst;
    ofs = '0;
    fwd = 1'b0;
    unique case (kind)
      KIND_STR: begin
        op = (idx == '0) ? OP_ADDR : OP_STORE;
        rg = (idx == '0) ? base : rfirst;
      end
      KIND_MOVD: begin
        op = OP_MOVE;
        rg = {rfirst[REG_W-1:1], idx[0]};
      end
      default: begin
        // run of words, optionally closed by the base writeback
        if (in_data) begin
          op  = is_load ? OP_LOAD : OP_STORE;
          rg  = rfirst + REG_W'(idx);
          ofs = OFS_W'(idx) * STRIDE;
          fwd = is_load && last_data;
        end else begin
          op  = OP_BASEWB;
          rg  = base;
          ofs = OFS_W'(ndata) * STRIDE;
        end
      end
    endcase
  end

endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
  import uop_cracker_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int CNT_W      = 4,
  parameter int OFS_W      = 8,
  parameter int WORD_BYTES = 4,
  parameter int MAX_RUN    = 8,
  parameter int WIDE_RUN   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_kind,
  input  logic [REG_W-1:0] in_base,
  input  logic [REG_W-1:0] in_rfirst,
  input  logic [CNT_W-1:0] in_count,
  input  logic             in_upd,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic [2:0]       uop_op,
  output logic [REG_W-1:0] uop_reg,
  output logic [OFS_W-1:0] uop_ofs,
  output logic             uop_first,
  output logic             uop_last,
  output logic             uop_fwd,
  output logic             err_o
);

  localparam int IW = CNT_W + 1;

  logic             legal;
  logic [CNT_W-1:0] n_data;
  logic [IW-1:0]    n_total;
  logic [2:0]       kind_q;
  logic [REG_W-1:0] base_q;
  logic [REG_W-1:0] rfirst_q;
  logic [CNT_W-1:0] ndata_q;
  logic [IW-1:0]    idx_q;
  logic             is_last;
  logic             busy_q;
  uop_op_e          op_w;

  uop_cracker_admit #(
    .CNT_W(CNT_W), .MAX_RUN(MAX_RUN), .WIDE_RUN(WIDE_RUN)
  ) u_admit (
    .kind(in_kind), .count(in_count), .upd(in_upd),
    .legal(legal), .n_data(n_data), .n_total(n_total)
  );

  uop_cracker_ctrl #(.REG_W(REG_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_base(in_base), .in_rfirst(in_rfirst),
    .legal(legal), .n_data(n_data), .n_total(n_total),
    .kind_q(kind_q), .base_q(base_q), .rfirst_q(rfirst_q),
    .ndata_q(ndata_q), .idx_q(idx_q), .is_last(is_last),
    .busy_q(busy_q), .uop_ready(uop_ready), .err_q(err_o)
  );

  uop_cracker_form #(
    .REG_W(REG_W), .CNT_W(CNT_W), .OFS_W(OFS_W), .WORD_BYTES(WORD_BYTES)
  ) u_form (
    .kind(kind_q), .base(base_q), .rfirst(rfirst_q), .ndata(ndata_q),
    .idx(idx_q), .op(op_w), .rg(uop_reg), .ofs(uop_ofs), .fwd(uop_fwd)
  );

  assign uop_valid = busy_q;
  assign uop_op    = op_w;
  assign uop_first = busy_q && (idx_q == '0);
  assign uop_last  = busy_q && is_last;

endmodule

// File: rtl/uop_cracker_chk.sv
module uop_cracker_chk #(
  parameter int REG_W = 5,
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             uop_valid,
  input logic             uop_ready,
  input logic [2:0]       uop_op,
  input logic [REG_W-1:0] uop_reg,
  input logic [OFS_W-1:0] uop_ofs,
  input logic             uop_first,
  input logic             uop_last,
  input logic             uop_fwd,
  input logic             err_o
);

  AST_IDLE_UNDER_RESET: assert property (@(posedge clk)
    !rst_n |-> (in_ready && !uop_valid && !err_o)); // R12

  AST_NO_UOP_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !uop_valid); // R9

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_ready && uop_last) |=> in_ready); // R9

  AST_FIRST_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((uop_valid && uop_first) || err_o)); // R4

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=>
      (uop_valid && $stable({uop_op, uop_reg, uop_ofs, uop_first, uop_last, uop_fwd}))); // R10

  AST_ERR_WITHOUT_UOP: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!uop_valid && in_ready)); // R11

  AST_FWD_ON_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_fwd) |-> (uop_op == 3'd0)); // R5

endmodule

bind uop_cracker uop_cracker_chk #(.REG_W(REG_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/uop_cracker_bench.sv
module uop_cracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;
  localparam int CNT_W = 4;
  localparam int OFS_W = 8;

  typedef struct {
    int    op;
    int    rg;
    int    ofs;
    bit    first;
    bit    last;
    bit    fwd;
    string tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [2:0]       in_kind = '0;
  logic [REG_W-1:0] in_base = '0;
  logic [REG_W-1:0] in_rfirst = '0;
  logic [CNT_W-1:0] in_count = '0;
  logic             in_upd = 1'b0;
  logic             uop_valid;
  logic             uop_ready = 1'b1;
  logic [2:0]       uop_op;
  logic [REG_W-1:0] uop_reg;
  logic [OFS_W-1:0] uop_ofs;
  logic             uop_first, uop_last, uop_fwd, err_o;

  int   checks = 0;
  int   failures = 0;
  exp_t q[$];
  bit   stall_mode = 1'b0;
  bit   hold_ready = 1'b0;

  uop_cracker u_uop_cracker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_base(in_base), .in_rfirst(in_rfirst),
    .in_count(in_count), .in_upd(in_upd), .uop_valid(uop_valid),
    .uop_ready(uop_ready), .uop_op(uop_op), .uop_reg(uop_reg),
    .uop_ofs(uop_ofs), .uop_first(uop_first), .uop_last(uop_last),
    .uop_fwd(uop_fwd), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic push(input int op, input int rg, input int ofs, input bit f,
                      input bit l, input bit w, input string tag);
    exp_t e;
    e.op = op; e.rg = rg; e.ofs = ofs; e.first = f; e.last = l; e.fwd = w; e.tag = tag;
    q.push_back(e);
  endtask

  // expected stream computed from the requirements
  task automatic expect_instr(input int kind, input int base, input int rf,
                              input int cnt, input bit upd);
    case (kind)
      0, 1: begin
        for (int i = 0; i < cnt; i++)
          push(kind, (rf + i) % 32, 4 * i, i == 0, (i == cnt - 1) && !upd,
               (kind == 0) && (i == cnt - 1), "R2/R4/R5");
        if (upd) push(4, base, 4 * cnt, 1'b0, 1'b1, 1'b0, "R3");
      end
      2: begin
        push(0, rf, 0, 1'b1, 1'b0, 1'b1, "R6");
        push(4, base, 4, 1'b0, 1'b1, 1'b0, "R6");
      end
      3: begin
        push(3, base, 0, 1'b1, 1'b0, 1'b0, "R7");
        push(1, rf, 0, 1'b0, 1'b1, 1'b0, "R7");
      end
      default: begin
        push(2, rf & 30, 0, 1'b1, 1'b0, 1'b0, "R8");
        push(2, rf | 1, 0, 1'b0, 1'b1, 1'b0, "R8");
      end
    endcase
  endtask

  task automatic drive(input int kind, input int base, input int rf,
                       input int cnt, input bit upd);
    @(posedge clk); #1;
    in_kind = 3'(kind); in_base = REG_W'(base); in_rfirst = REG_W'(rf);
    in_count = CNT_W'(cnt); in_upd = upd; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic run_good(input int kind, input int base, input int rf,
                          input int cnt, input bit upd);
    expect_instr(kind, base, rf, cnt, upd);
    drive(kind, base, rf, cnt, upd);
    wait (q.size() == 0);
    @(negedge clk);
    check(in_ready == 1'b1 && uop_valid == 1'b0,
          $sformatf("R9 ready after sequence: ready=%0b valid=%0b expected 1 0", in_ready, uop_valid));
  endtask

  task automatic run_bad(input int kind, input int cnt, input string tag);
    drive(kind, 3, 4, cnt, 1'b1);
    @(negedge clk);
    check(err_o == 1'b1 && uop_valid == 1'b0 && in_ready == 1'b1,
          $sformatf("%s reject kind=%0d cnt=%0d: err=%0b valid=%0b ready=%0b expected 1 0 1",
                    tag, kind, cnt, err_o, uop_valid, in_ready));
    @(negedge clk);
    check(err_o == 1'b0 && uop_valid == 1'b0,
          $sformatf("%s error pulse length: err=%0b valid=%0b expected 0 0", tag, err_o, uop_valid));
  endtask

  // consumer back-pressure
  always @(posedge clk) begin
    #1;
    if (hold_ready) uop_ready <= 1'b0;
    else if (stall_mode) uop_ready <= ($urandom % 3) != 0;
    else uop_ready <= 1'b1;
  end

  // monitor: pops expected items as transfers are about to happen
  initial begin
    bit prev_stall = 1'b0;
    logic [2:0] p_op; logic [REG_W-1:0] p_rg; logic [OFS_W-1:0] p_ofs;
    logic p_f, p_l, p_w;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_stall = 1'b0;
      end else begin
        if (uop_valid) begin
          check(in_ready == 1'b0, $sformatf("R9 ready during sequence: got %0b expected 0", in_ready));
        end
        if (prev_stall) begin
          check(uop_valid && uop_op == p_op && uop_reg == p_rg && uop_ofs == p_ofs &&
                uop_first == p_f && uop_last == p_l && uop_fwd == p_w,
                $sformatf("R10 hold: got op=%0d reg=%0d expected op=%0d reg=%0d",
                          uop_op, uop_reg, p_op, p_rg));
        end
        prev_stall = uop_valid && !uop_ready;
        p_op = uop_op; p_rg = uop_reg; p_ofs = uop_ofs;
        p_f = uop_first; p_l = uop_last; p_w = uop_fwd;
        if (uop_valid && uop_ready) begin
          if (q.size() == 0) begin
            check(1'b0, $sformatf("R11 unexpected micro-op op=%0d reg=%0d expected none", uop_op, uop_reg));
          end else begin
            exp_t e;
            e = q.pop_front();
            check(int'(uop_op) == e.op && int'(uop_reg) == e.rg && int'(uop_ofs) == e.ofs &&
                  uop_first == e.first && uop_last == e.last && uop_fwd == e.fwd,
                  $sformatf("%s uop: got op=%0d reg=%0d ofs=%0d f=%0b l=%0b w=%0b expected op=%0d reg=%0d ofs=%0d f=%0b l=%0b w=%0b",
                            e.tag, uop_op, uop_reg, uop_ofs, uop_first, uop_last, uop_fwd,
                            e.op, e.rg, e.ofs, e.first, e.last, e.fwd));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && uop_valid == 1'b0 && err_o == 1'b0,
          $sformatf("R1 reset state: ready=%0b valid=%0b err=%0b expected 1 0 0", in_ready, uop_valid, err_o));
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && uop_valid == 1'b0,
          $sformatf("R1 after release: ready=%0b valid=%0b expected 1 0", in_ready, uop_valid));

    run_good(0, 2, 5, 3, 1'b0);    // R2 plain load run
    stall_mode = 1'b1;              // R10 back-pressure from here
    run_good(1, 6, 10, 8, 1'b1);   // R2 R3 store run with writeback
    run_good(0, 1, 28, 12, 1'b1);  // R2 wide run with register wrap, R3
    run_good(0, 9, 0, 1, 1'b0);    // R4 single-word run: first and last together
    run_good(1, 4, 7, 5, 1'b0);    // R5 no forward on stores
    run_good(2, 7, 9, 0, 1'b0);    // R6 load with update, count ignored
    run_good(3, 12, 20, 6, 1'b1);  // R7 register-offset store
    run_good(4, 0, 11, 3, 1'b1);   // R8 double move from odd register
    run_good(4, 0, 16, 0, 1'b0);   // R8 double move from even register
    stall_mode = 1'b0;

    run_bad(0, 0, "R11");
    run_bad(1, 9, "R11");
    run_bad(0, 13, "R11");
    run_bad(5, 4, "R13");
    run_bad(7, 2, "R13");
    run_good(0, 3, 3, 2, 1'b1);    // R11 block still works after rejects

    // R12 reset in the middle of a sequence
    hold_ready = 1'b1;
    expect_instr(0, 1, 2, 8, 1'b0);
    drive(0, 1, 2, 8, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && uop_valid == 1'b0 && err_o == 1'b0,
          $sformatf("R12 mid-sequence reset: ready=%0b valid=%0b err=%0b expected 1 0 0",
                    in_ready, uop_valid, err_o));
    q.delete();
    hold_ready = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(uop_valid == 1'b0 && in_ready == 1'b1,
          $sformatf("R12 stays idle after release: valid=%0b ready=%0b expected 0 1", uop_valid, in_ready));
    run_good(1, 30, 31, 4, 1'b1);  // R2 R3 after recovery, wraps past 31

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule